// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small processor core that completes one instruction per clock. It fetches a 32-bit word from an internal instruction store at the current program counter, decodes it and reads two operands from a 32-entry register file. In the same cycle it computes a result or memory address, and on the clock edge it commits the register write, the data-memory store and the next program counter. It understands three fixed 32-bit instruction layouts: register, immediate and jump. It executes a subset of arithmetic, logic, shift, compare, word load/store and jump-and-link operations.

The instruction store is filled through a write port, normally while the core is held in reset. The data store is word addressed, and the byte address is reduced to a word index. A debug path shows the program counter and the contents of any one register, so a program's effect can be read at the ports without stopping the core. There is no delay slot: the instruction after a jump is never executed.

Top module: `sc_core32`

## Requirements
- R1: While `rst_n` is low at a clock edge, the program counter becomes 0 and every register becomes 0. After release, the first instruction executed is word 0.
- R2: Register 0 always reads as zero, and any write aimed at it is discarded.
- R3: Field layout is opcode[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6], funct[5:0]. Opcode 0 selects by funct: add 0x20 (rd=rs+rt), xor 0x26, and slt 0x2A, which writes 1 to rd when rs<rt as signed values and 0 otherwise. Example: 0x00622020 adds r3 and r2 into r4.
- R4: sll (funct 0x00) shifts rt left by shamt. sra (funct 0x03) shifts rt right by shamt and fills with the sign bit. sllv (funct 0x04) shifts rt left by the low 5 bits of rs. Example: 0x000519C0 writes r5<<7 into r3.
- R5: addi (opcode 0x08) writes rs plus the sign-extended imm[15:0] into rt. Additions wrap modulo 2^32 and raise no trap.
- R6: lw (opcode 0x23) loads into rt and sw (opcode 0x2B) stores rt. Both use the byte address rs + sign-extended imm[15:0], and the word index is that address shifted right by 2 and reduced modulo the data-store depth. Example: 0x8C450BB8 loads from r2+3000 into r5.
- R7: jal (opcode 0x03) writes PC+4 into r31 and jumps to {PC+4[31:28], target[25:0], 2'b00}. The following word is not executed.
- R8: jr (funct 0x08) jumps to the value of rs. jalr (funct 0x09) jumps to the value rs held before the instruction and writes PC+4 into rd, even when rd equals rs.
- R9: Every non-jump instruction advances the PC by 4. An unrecognised opcode or funct changes no register and no memory word.
- R10: While `load_en` is high, `load_data` is written to instruction word `load_addr`. `dbg_pc` shows the PC and `dbg_reg` shows register `dbg_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Instruction-store write enable |
| load_addr | input | IAW (6) | Instruction word index to write |
| load_data | input | 32 | Instruction word to write |
| dbg_sel | input | 5 | Register number shown on dbg_reg |
| dbg_reg | output | 32 | Contents of the selected register |
| dbg_pc | output | 32 | Current program counter |

## Verification
Two functions meet in a single cycle when a jalr names the same register as both its jump source and its link destination. The target must come from the value the register held before the edge, and the link must land on the same edge. The bench provokes this with `jalr r1,r1` and then returns through `jr r1`. It judges the result by the PC after each jump and by the final value of r1. Load and store are also paired back to back, so each read follows its store by one cycle.

// File: rtl/sc_core_pkg.sv
// Package: shared encodings and control types for the single-cycle core.
// Assumes a 32-bit word and the three fixed instruction layouts.
package sc_core_pkg;

    localparam int XLEN = 32;
    localparam int RAW  = 5;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_JAL   = 6'h03;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;

    localparam logic [5:0] FN_SLL  = 6'h00;
    localparam logic [5:0] FN_SRA  = 6'h03;
    localparam logic [5:0] FN_SLLV = 6'h04;
    localparam logic [5:0] FN_JR   = 6'h08;
    localparam logic [5:0] FN_JALR = 6'h09;
    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_XOR  = 6'h26;
    localparam logic [5:0] FN_SLT  = 6'h2A;

    localparam logic [RAW-1:0] LINK_REG = 5'd31;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_XOR, ALU_SLL, ALU_SRA, ALU_SLLV, ALU_SLT
    } alu_op_e;

    typedef enum logic [1:0] { WB_ALU, WB_MEM, WB_LINK } wb_sel_e;
    typedef enum logic [1:0] { DST_RD, DST_RT, DST_LINK } dst_sel_e;
    typedef enum logic [1:0] { PC_SEQ, PC_JTGT, PC_REG } pc_sel_e;

    typedef struct packed {
        logic     reg_we;
        dst_sel_e dst_sel;
        wb_sel_e  wb_sel;
        alu_op_e  alu_op;
        logic     use_imm;
        logic     mem_we;
        pc_sel_e  pc_sel;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
// Module: sc_decode
// Turns one instruction word into a control bundle. Purely combinational.
// Assumes unknown opcodes/functs must behave as a no-op with sequential PC.
module sc_decode
    import sc_core_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);

    logic [5:0] opc;
    logic [5:0] fn;

    assign opc = instr[31:26];
    assign fn  = instr[5:0];

    // Decode opcode/funct into control fields; default is a no-op.
    always_comb begin
        ctrl         = '0;
        ctrl.dst_sel = DST_RD;
        ctrl.wb_sel  = WB_ALU;
        ctrl.alu_op  = ALU_ADD;
        ctrl.pc_sel  = PC_SEQ;
        unique case (opc)
            OP_RTYPE: begin
                case (fn)
                    FN_ADD:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_ADD;  end
                    FN_XOR:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_XOR;  end
                    FN_SLT:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SLT;  end
                    FN_SLL:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SLL;  end
                    FN_SRA:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SRA;  end
                    FN_SLLV: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SLLV; end
                    FN_JR:   begin ctrl.pc_sel = PC_REG; end
                    FN_JALR: begin
                        ctrl.reg_we = 1'b1;
                        ctrl.wb_sel = WB_LINK;
                        ctrl.pc_sel = PC_REG;
                    end
                    default: ;
                endcase
            end
            OP_ADDI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.dst_sel = DST_RT;
                ctrl.use_imm = 1'b1;
            end
            OP_LW: begin
                ctrl.reg_we  = 1'b1;
                ctrl.dst_sel = DST_RT;
                ctrl.wb_sel  = WB_MEM;
                ctrl.use_imm = 1'b1;
            end
            OP_SW: begin
                ctrl.mem_we  = 1'b1;
                ctrl.use_imm = 1'b1;
            end
            OP_JAL: begin
                ctrl.reg_we  = 1'b1;
                ctrl.dst_sel = DST_LINK;
                ctrl.wb_sel  = WB_LINK;
                ctrl.pc_sel  = PC_JTGT;
            end
            default: ;
        endcase
    end

    // R6: a store never also writes the register file.
    always_comb begin
        ctrl_excl_chk: assert ($onehot0({ctrl.mem_we, ctrl.reg_we}));
    end

endmodule

// File: rtl/sc_regfile.sv
// Module: sc_regfile
// Register file with two operand read ports and one debug read port.
// Assumes entry 0 is never written, so it keeps its reset value of zero.
module sc_regfile
    import sc_core_pkg::*;
#(
    parameter int NREG = 32,
    parameter int W    = XLEN
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NREG)-1:0] ra_a,
    input  logic [$clog2(NREG)-1:0] ra_b,
    input  logic [$clog2(NREG)-1:0] ra_dbg,
    output logic [W-1:0]            rd_a,
    output logic [W-1:0]            rd_b,
    output logic [W-1:0]            rd_dbg,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] wa,
    input  logic [W-1:0]            wd
);

    logic [W-1:0] regs [NREG];

    // Clear all entries on reset; write a non-zero entry when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    // Asynchronous read of all three ports.
    always_comb begin
        rd_a   = regs[ra_a];
        rd_b   = regs[ra_b];
        rd_dbg = regs[ra_dbg];
    end

    // R2: a write to a non-zero entry is visible on the following cycle.
    wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa != '0) |=> (regs[$past(wa)] == $past(wd)));

    // R2: entry zero holds zero whatever was written.
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa == '0) |=> (rd_a == '0 || ra_a != '0));

endmodule

// File: rtl/sc_alu.sv
// Module: sc_alu
// Arithmetic, logic, shift and signed compare. Purely combinational.
// Assumes opa is the rs value and opb is rt or the extended immediate.
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e               op,
    input  logic [W-1:0]          opa,
    input  logic [W-1:0]          opb,
    input  logic [$clog2(W)-1:0]  shamt,
    output logic [W-1:0]          res
);

    localparam int SW = $clog2(W);

    // Select the operation result.
    always_comb begin
        unique case (op)
            ALU_ADD:  res = opa + opb;
            ALU_XOR:  res = opa ^ opb;
            ALU_SLL:  res = opb << shamt;
            ALU_SRA:  res = $unsigned($signed(opb) >>> shamt);
            ALU_SLLV: res = opb << opa[SW-1:0];
            ALU_SLT:  res = {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))};
            default:  res = '0;
        endcase
    end

    // R3: a compare result is a single bit.
    always_comb begin
        if (op == ALU_SLT) begin
            slt_bool_chk: assert (res[W-1:1] == '0);
        end
    end

endmodule

// File: rtl/sc_wordmem.sv
// Module: sc_wordmem
// Word memory with one synchronous write port and one asynchronous read port.
// Assumes no reset of contents; callers initialise what they read.
module sc_wordmem #(
    parameter int DEPTH = 64,
    parameter int W     = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);

    logic [W-1:0] mem [DEPTH];

    // Store a word when enabled.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read the addressed word.
    assign rdata = mem[raddr];

    // R6: a stored word is present on the next cycle.
    store_vis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/sc_core32.sv
// Module: sc_core32
// Single-cycle core: fetch, decode, operand read, execute, memory and
// write-back all complete in the cycle of the instruction.
// Assumes the instruction store is loaded before reset is released, and
// that fetch uses only the word-index bits of the PC.
module sc_core32
    import sc_core_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic [IAW-1:0]  load_addr,
    input  logic [31:0]     load_data,
    input  logic [4:0]      dbg_sel,
    output logic [31:0]     dbg_reg,
    output logic [31:0]     dbg_pc
);

    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] pc_next;
    logic [XLEN-1:0] instr;
    ctrl_t           ctrl;

    logic [RAW-1:0]  f_rs, f_rt, f_rd;
    logic [4:0]      f_shamt;
    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] jtgt;

    logic [XLEN-1:0] rs_val, rt_val;
    logic [XLEN-1:0] alu_b, alu_res;
    logic [XLEN-1:0] mem_rdata;
    logic [XLEN-1:0] wb_data;
    logic [RAW-1:0]  wb_addr;

    // Instruction store, written only through the load port.
    sc_wordmem #(.DEPTH(IMEM_WORDS), .W(XLEN)) u_imem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (load_en),
        .waddr (load_addr),
        .wdata (load_data),
        .raddr (pc[IAW+1:2]),
        .rdata (instr)
    );

    assign f_rs    = instr[25:21];
    assign f_rt    = instr[20:16];
    assign f_rd    = instr[15:11];
    assign f_shamt = instr[10:6];
    assign imm_sx  = {{16{instr[15]}}, instr[15:0]};
    assign pc_plus4 = pc + 32'd4;
    assign jtgt    = {pc_plus4[31:28], instr[25:0], 2'b00};

    sc_decode u_dec (
        .instr (instr),
        .ctrl  (ctrl)
    );

    sc_regfile #(.NREG(32), .W(XLEN)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_a   (f_rs),
        .ra_b   (f_rt),
        .ra_dbg (dbg_sel),
        .rd_a   (rs_val),
        .rd_b   (rt_val),
        .rd_dbg (dbg_reg),
        .we     (ctrl.reg_we),
        .wa     (wb_addr),
        .wd     (wb_data)
    );

    assign alu_b = ctrl.use_imm ? imm_sx : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .op    (ctrl.alu_op),
        .opa   (rs_val),
        .opb   (alu_b),
        .shamt (f_shamt),
        .res   (alu_res)
    );

    // Data store, word index taken from the computed byte address.
    sc_wordmem #(.DEPTH(DMEM_WORDS), .W(XLEN)) u_dmem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctrl.mem_we),
        .waddr (alu_res[DAW+1:2]),
        .wdata (rt_val),
        .raddr (alu_res[DAW+1:2]),
        .rdata (mem_rdata)
    );

    // Choose the register to write and the value written.
    always_comb begin
        unique case (ctrl.dst_sel)
            DST_RT:   wb_addr = f_rt;
            DST_LINK: wb_addr = LINK_REG;
            default:  wb_addr = f_rd;
        endcase
        unique case (ctrl.wb_sel)
            WB_MEM:  wb_data = mem_rdata;
            WB_LINK: wb_data = pc_plus4;
            default: wb_data = alu_res;
        endcase
    end

    // Choose the next program counter.
    always_comb begin
        unique case (ctrl.pc_sel)
            PC_JTGT: pc_next = jtgt;
            PC_REG:  pc_next = rs_val;
            default: pc_next = pc_plus4;
        endcase
    end

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_next;
    end

    assign dbg_pc = pc;

    // R9
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.pc_sel == PC_SEQ) |=> (pc == $past(pc) + 32'd4));

    // R7
    jal_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.pc_sel == PC_JTGT) |=>
            (pc[27:2] == $past(instr[25:0]) && pc[1:0] == 2'b00));

    // R8
    reg_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.pc_sel == PC_REG) |=> (pc == $past(rs_val)));

endmodule

// File: tb/tb_sc_core32.sv
`timescale 1ns/1ps
// Bench: loads short programs, runs them from reset and compares register
// and PC values against results computed here from the requirements.
module tb_sc_core32;

    localparam int IW = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [4:0]  dbg_sel = '0;
    logic [31:0] dbg_reg;
    logic [31:0] dbg_pc;

    int checks = 0;
    int errors = 0;
    logic [31:0] prog [IW];

    always #2 clk = ~clk;

    sc_core32 dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .dbg_sel(dbg_sel), .dbg_reg(dbg_reg),
        .dbg_pc(dbg_pc)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
    endfunction

    function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] sx(int v);
        return {{16{v[15]}}, v[15:0]};
    endfunction

    task automatic clear_prog();
        for (int i = 0; i < IW; i++) prog[i] = 32'h0;
    endtask

    // Hold reset, load the whole store, release and run n instructions.
    task automatic run(int n);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < IW; i++) begin
            load_en = 1'b1; load_addr = 6'(i); load_data = prog[i];
            @(negedge clk);
        end
        load_en = 1'b0;
        rst_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_reg(string tag, int r, logic [31:0] exp);
        dbg_sel = 5'(r);
        #0.5;
        chk(tag, dbg_reg, exp);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int vals[8] = '{0, 1, -1, 32767, -32768, 4660, -2, 256};

        // R1: reset state
        clear_prog();
        prog[0] = enc_i(8, 0, 5, 9);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 pc in reset", dbg_pc, 32'h0);
        chk_reg("R1 reg in reset", 5, 32'h0);
        run(1);
        chk_reg("R1 first fetch word0", 5, 32'd9);

        // R3 R5: sweep of operand pairs
        for (int ia = 0; ia < 8; ia++) begin
            for (int ib = 0; ib < 8; ib++) begin
                logic [31:0] a, b;
                a = sx(vals[ia]); b = sx(vals[ib]);
                clear_prog();
                prog[0] = enc_i(8, 0, 1, vals[ia]);
                prog[1] = enc_i(8, 0, 2, vals[ib]);
                prog[2] = enc_r(1, 2, 3, 0, 32'h20);
                prog[3] = enc_r(1, 2, 4, 0, 32'h26);
                prog[4] = enc_r(1, 2, 5, 0, 32'h2A);
                prog[5] = enc_r(2, 1, 6, 0, 32'h2A);
                prog[6] = enc_i(8, 1, 7, vals[ib]);
                run(7);
                chk_reg("R3 add", 3, a + b);
                chk_reg("R3 xor", 4, a ^ b);
                chk_reg("R3 slt", 5, {31'd0, $signed(a) < $signed(b)});
                chk_reg("R3 slt swapped", 6, {31'd0, $signed(b) < $signed(a)});
                chk_reg("R5 addi", 7, a + b);
            end
        end

        // R5: wrap without trap
        clear_prog();
        prog[0] = enc_i(8, 0, 1, 1);
        prog[1] = enc_r(0, 1, 1, 31, 0);
        prog[2] = enc_i(8, 1, 2, -1);
        prog[3] = enc_i(8, 2, 3, 1);
        prog[4] = enc_r(1, 1, 4, 0, 32'h20);
        run(5);
        chk_reg("R5 max positive", 2, 32'h7FFFFFFF);
        chk_reg("R5 addi wrap", 3, 32'h80000000);
        chk_reg("R5 add wrap", 4, 32'h0);

        // R4: all shift amounts
        for (int s = 0; s < 32; s++) begin
            logic [31:0] n, p;
            n = sx(-4661); p = 32'h4321;
            clear_prog();
            prog[0] = enc_i(8, 0, 1, -4661);
            prog[1] = enc_i(8, 0, 2, s + 32);
            prog[2] = enc_r(0, 1, 3, s, 32'h00);
            prog[3] = enc_r(0, 1, 4, s, 32'h03);
            prog[4] = enc_r(2, 1, 5, 0, 32'h04);
            prog[5] = enc_i(8, 0, 6, 32'h4321);
            prog[6] = enc_r(0, 6, 7, s, 32'h03);
            run(7);
            chk_reg("R4 sll", 3, n << s);
            chk_reg("R4 sra negative", 4, $unsigned($signed(n) >>> s));
            chk_reg("R4 sllv low5", 5, n << s);
            chk_reg("R4 sra positive", 7, p >> s);
        end

        // R3 R4 R6: literal encodings
        clear_prog();
        prog[0] = enc_i(8, 0, 3, 10);
        prog[1] = enc_i(8, 0, 2, -3);
        prog[2] = 32'h00622020;
        prog[3] = enc_i(8, 0, 5, 3);
        prog[4] = 32'h000519C0;
        prog[5] = enc_i(8, 0, 2, -2984);
        prog[6] = enc_i(8, 0, 6, 99);
        prog[7] = enc_i(32'h2B, 0, 6, 16);
        prog[8] = 32'h8C450BB8;
        run(9);
        chk_reg("R3 literal add", 4, 32'd7);
        chk_reg("R4 literal sll", 3, 32'd384);
        chk_reg("R6 literal lw", 5, 32'd99);

        // R6: store then load with positive and negative offsets
        clear_prog();
        prog[0] = enc_i(8, 0, 1, 8);
        prog[1] = enc_i(8, 0, 2, -77);
        prog[2] = enc_i(32'h2B, 1, 2, 4);
        prog[3] = enc_i(32'h23, 0, 3, 12);
        prog[4] = enc_i(8, 0, 2, 55);
        prog[5] = enc_i(32'h2B, 1, 2, -4);
        prog[6] = enc_i(32'h23, 0, 4, 4);
        prog[7] = enc_i(32'h23, 1, 5, 4);
        run(8);
        chk_reg("R6 lw after sw", 3, sx(-77));
        chk_reg("R6 negative offset", 4, 32'd55);
        chk_reg("R6 word kept", 5, sx(-77));

        // R2: register zero
        clear_prog();
        prog[0] = enc_i(8, 0, 0, 5);
        prog[1] = enc_r(0, 0, 1, 0, 32'h20);
        run(2);
        chk_reg("R2 r0 reads zero", 0, 32'h0);
        chk_reg("R2 r0 as source", 1, 32'h0);

        // R7: jal skips the next word and links
        clear_prog();
        prog[0] = {6'h03, 26'd5};
        prog[1] = enc_i(8, 0, 8, 1);
        prog[5] = enc_i(8, 0, 9, 2);
        run(1);
        chk("R7 jal target", dbg_pc, 32'h14);
        chk_reg("R7 link r31", 31, 32'h4);
        @(negedge clk);
        chk_reg("R7 no delay slot", 8, 32'h0);
        chk_reg("R7 target executed", 9, 32'd2);

        // R8: jalr to a different rd and jr return
        clear_prog();
        prog[0] = enc_i(8, 0, 1, 24);
        prog[1] = enc_r(1, 0, 5, 0, 32'h09);
        prog[2] = enc_i(8, 0, 8, 7);
        prog[6] = enc_i(8, 0, 9, 3);
        prog[7] = enc_r(5, 0, 0, 0, 32'h08);
        run(2);
        chk("R8 jalr target", dbg_pc, 32'd24);
        chk_reg("R8 jalr link", 5, 32'd8);
        repeat (3) @(negedge clk);
        chk_reg("R8 target body", 9, 32'd3);
        chk_reg("R8 jr return", 8, 32'd7);

        // R8: jalr with rd == rs
        clear_prog();
        prog[0] = enc_i(8, 0, 1, 12);
        prog[1] = enc_r(1, 0, 1, 0, 32'h09);
        prog[2] = enc_i(8, 0, 2, 5);
        prog[3] = enc_r(1, 0, 0, 0, 32'h08);
        run(2);
        chk("R8 same-reg target", dbg_pc, 32'd12);
        chk_reg("R8 same-reg link", 1, 32'd8);
        repeat (2) @(negedge clk);
        chk_reg("R8 same-reg return", 2, 32'd5);

        // R9: unknown opcode and funct are no-ops
        clear_prog();
        prog[0] = enc_i(8, 0, 1, 5);
        prog[1] = 32'hFC21FFFF;
        prog[2] = enc_r(1, 1, 1, 0, 32'h3F);
        run(3);
        chk("R9 pc advance", dbg_pc, 32'd12);
        chk_reg("R9 unknown no effect", 1, 32'd5);

        // R10: debug shows another register
        chk_reg("R10 debug r0", 0, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule